// File: doc/BRIEF.md
# Descriptor Slot Ring Queue

This block holds a circular queue of fixed-size transfer descriptors in a small register file. A host writes each descriptor as 16-bit words into the slot that the write pointer names, then pulses an advance input to publish it. A consumer engine sees the descriptor at the read pointer on its outputs (optional flags word, 32-bit block address, block size) and pops it when done. The data that a descriptor points to is never touched here. A parameter chooses between a four-word slot with a flags word and a three-word slot without one.

Software programs the slot region length in words, a low-water threshold in slots, and an interrupt enable mask through a narrow control write port. When a pop takes the fill level below the threshold, a sticky refill status bit is set. The host clears it with a write-one acknowledge. The occupancy tracker is a three-state machine: EMPTY, PARTIAL and FULL. Its transitions are FILL (EMPTY to PARTIAL on an accepted advance), TOP-OFF (to FULL when an advance takes the queue to capacity), RELEASE (FULL to PARTIAL on an accepted pop), DRAIN (to EMPTY when a pop removes the last slot) and RELOAD (any state to EMPTY on a region write). In a two-slot region, TOP-OFF can leave EMPTY directly and DRAIN can leave FULL directly.

Top module: `desc_ring_queue`

## Requirements
- R1: Slot s starts at word address s times the words per slot. In the four-word variant the words are, in order, flags, address bits 31:16, address bits 15:0 and size. In the three-word variant they are address bits 31:16, address bits 15:0 and size, and `cons_flags` reads 0.
- R2: A control write with `ctl_sel` = 0 sets the slot count to max(2, min(value, MAX_WORDS) / words per slot). It returns both pointers and the fill level to 0. The queue then holds at most one less descriptor than the slot count.
- R3: `q_full` is high exactly when the fill level equals the slot count minus one. An advance while full changes nothing.
- R4: `cons_valid` is high exactly when the read and write pointers differ. A pop while empty changes nothing.
- R5: Descriptors reach the consumer in the order they were advanced. Both pointers wrap to slot 0 after the last slot.
- R6: An advance and a pop in the same cycle both take effect when the queue is neither full nor empty. The fill level is then unchanged.
- R7: A pop without an advance that takes the fill level from the threshold to one below it sets the refill status bit. This is bit 1 (0x0002) in the four-word variant and bit 3 (0x0008) in the three-word variant. The bit stays set until acknowledged. A threshold of 0 never sets it. A threshold is written with `ctl_sel` = 1.
- R8: A control write with `ctl_sel` = 3 clears the status bit when the written value has a 1 at that bit's position. Other written bits have no effect.
- R9: `irq` is high when the status bit is set and the same bit of the enable mask is 1. The mask is written with `ctl_sel` = 2.
- R10: After reset the queue is empty and not full. The slot count is MAX_WORDS / words per slot. Threshold, enable mask, status and `irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| slot_wr_en | input | 1 | Write one descriptor word |
| slot_wr_addr | input | $clog2(MAX_WORDS) | Word address in the slot region |
| slot_wr_data | input | 16 | Descriptor word |
| wr_advance | input | 1 | Publish the slot at the write pointer |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_sel | input | 2 | 0 region words, 1 threshold, 2 enable mask, 3 acknowledge |
| ctl_wdata | input | 16 | Control write value |
| cons_pop | input | 1 | Consumer has finished the head descriptor |
| cons_valid | output | 1 | Head descriptor present |
| cons_flags | output | 16 | Head flags word (0 in three-word variant) |
| cons_addr | output | 32 | Head block address |
| cons_size | output | 16 | Head block size |
| fill_level | output | $clog2(MAX_WORDS/words per slot + 1) | Published descriptors not yet popped |
| q_full | output | 1 | No free slot |
| irq_status | output | 16 | Refill status, one bit used |
| irq | output | 1 | Enabled refill request |

## Verification
On every cycle the assertions check the following properties. The valid output agrees with the pointer comparison. The fill level stays below the slot count. Pointers stay inside the region. An advance while full or a pop while empty leaves the queue unchanged. A region write empties the queue. A threshold crossing sets the status bit, and an acknowledge clears it. Only the bench scenarios can show the slot-count arithmetic for each region length, the word layout of each variant, descriptor ordering across wraps, and the sticky and masked behaviour of the refill request.

// File: rtl/qr_pkg.sv
package qr_pkg;

    typedef enum logic [1:0] {
        Q_EMPTY   = 2'd0,
        Q_PARTIAL = 2'd1,
        Q_FULL    = 2'd2
    } q_state_e;

    localparam logic [1:0] SEL_REGION = 2'd0;
    localparam logic [1:0] SEL_THRESH = 2'd1;
    localparam logic [1:0] SEL_ENABLE = 2'd2;
    localparam logic [1:0] SEL_ACK    = 2'd3;

    localparam int WORD_W = 16;

endpackage

// File: rtl/qr_ptr_fsm.sv
module qr_ptr_fsm
    import qr_pkg::*;
#(
    parameter int SLOT_W      = 4,
    parameter int CNT_W       = 5,
    parameter int RESET_SLOTS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_req,
    input  logic              pop_req,
    input  logic              reload,
    input  logic [CNT_W-1:0]  reload_slots,
    output logic [SLOT_W-1:0] wr_ptr,
    output logic [SLOT_W-1:0] rd_ptr,
    output logic [CNT_W-1:0]  count,
    output logic [CNT_W-1:0]  nslots,
    output logic              push_ok,
    output logic              pop_ok,
    output logic              full,
    output logic              nonempty
);

    q_state_e          state, state_nx;
    logic [CNT_W-1:0]  cap;

    assign cap = nslots - 1'b1;

    function automatic logic [SLOT_W-1:0] bump(input logic [SLOT_W-1:0] p,
                                               input logic [CNT_W-1:0]  last);
        return (CNT_W'(p) == last) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        push_ok = push_req && !reload && (state != Q_FULL);
        pop_ok  = pop_req  && !reload && (state != Q_EMPTY);
    end

    // next-state: FILL, TOP-OFF, RELEASE, DRAIN, RELOAD
    always_comb begin
        state_nx = state;
        if (reload) begin
            state_nx = Q_EMPTY;
        end else begin
            unique case (state)
                Q_EMPTY: begin
                    if (push_ok)
                        state_nx = (cap == 1) ? Q_FULL : Q_PARTIAL;
                end
                Q_PARTIAL: begin
                    if (push_ok && !pop_ok && count == cap - 1'b1)
                        state_nx = Q_FULL;
                    else if (pop_ok && !push_ok && count == 1)
                        state_nx = Q_EMPTY;
                end
                Q_FULL: begin
                    if (pop_ok)
                        state_nx = (cap == 1) ? Q_EMPTY : Q_PARTIAL;
                end
                default: state_nx = Q_EMPTY;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= Q_EMPTY;
        else        state <= state_nx;
    end

    always_comb begin
        full     = (state == Q_FULL);
        nonempty = (state != Q_EMPTY);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            nslots <= CNT_W'(RESET_SLOTS);
        end else if (reload) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            nslots <= reload_slots;
        end else begin
            if (push_ok) wr_ptr <= bump(wr_ptr, cap);
            if (pop_ok)  rd_ptr <= bump(rd_ptr, cap);
            unique case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/qr_slot_store.sv
module qr_slot_store #(
    parameter int MAX_WORDS = 64,
    parameter int WPS       = 4,
    parameter bit HAS_FLAGS = 1'b1,
    parameter int AW        = 6,
    parameter int SLOT_W    = 4
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [15:0]       wr_data,
    input  logic [SLOT_W-1:0] rd_slot,
    output logic [15:0]       flags,
    output logic [31:0]       addr,
    output logic [15:0]       size
);

    localparam int OFS = HAS_FLAGS ? 1 : 0;

    logic [15:0]   mem [MAX_WORDS];
    logic [AW-1:0] base;

    always_ff @(posedge clk) begin
        if (wr_en && int'(wr_addr) < MAX_WORDS)
            mem[wr_addr] <= wr_data;
    end

    assign base = AW'(int'(rd_slot) * WPS);

    always_comb begin
        addr = {mem[base + AW'(OFS)], mem[base + AW'(OFS + 1)]};
        size = mem[base + AW'(OFS + 2)];
    end

    generate
        if (HAS_FLAGS) begin : g_flags
            assign flags = mem[base];
        end else begin : g_noflags
            assign flags = '0;
        end
    endgenerate

endmodule

// File: rtl/qr_refill_irq.sv
module qr_refill_irq
    import qr_pkg::*;
#(
    parameter int CNT_W    = 5,
    parameter int STAT_BIT = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic [1:0]       ctl_sel,
    input  logic [15:0]      ctl_wdata,
    input  logic             push_ok,
    input  logic             pop_ok,
    input  logic [CNT_W-1:0] count,
    output logic             drop_evt,
    output logic [15:0]      status,
    output logic             irq
);

    logic [CNT_W-1:0] thresh;
    logic [15:0]      enable;
    logic             pend;

    assign drop_evt = pop_ok && !push_ok && (thresh != '0) && (count == thresh);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            thresh <= '0;
            enable <= '0;
            pend   <= 1'b0;
        end else begin
            if (ctl_wr && ctl_sel == SEL_THRESH) thresh <= ctl_wdata[CNT_W-1:0];
            if (ctl_wr && ctl_sel == SEL_ENABLE) enable <= ctl_wdata;
            if (drop_evt)
                pend <= 1'b1;
            else if (ctl_wr && ctl_sel == SEL_ACK && ctl_wdata[STAT_BIT])
                pend <= 1'b0;
        end
    end

    assign status = 16'(pend) << STAT_BIT;
    assign irq    = |(status & enable);

endmodule

// File: rtl/desc_ring_queue.sv
module desc_ring_queue
    import qr_pkg::*;
#(
    parameter int  MAX_WORDS = 64,
    parameter bit  HAS_FLAGS = 1'b1,
    localparam int WPS       = HAS_FLAGS ? 4 : 3,
    localparam int MAX_SLOTS = MAX_WORDS / WPS,
    localparam int SLOT_W    = $clog2(MAX_SLOTS),
    localparam int CNT_W     = $clog2(MAX_SLOTS + 1),
    localparam int AW        = $clog2(MAX_WORDS),
    localparam int STAT_BIT  = HAS_FLAGS ? 1 : 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slot_wr_en,
    input  logic [AW-1:0]    slot_wr_addr,
    input  logic [15:0]      slot_wr_data,
    input  logic             wr_advance,
    input  logic             ctl_wr,
    input  logic [1:0]       ctl_sel,
    input  logic [15:0]      ctl_wdata,
    input  logic             cons_pop,
    output logic             cons_valid,
    output logic [15:0]      cons_flags,
    output logic [31:0]      cons_addr,
    output logic [15:0]      cons_size,
    output logic [CNT_W-1:0] fill_level,
    output logic             q_full,
    output logic [15:0]      irq_status,
    output logic             irq
);

    logic              region_wr;
    logic [CNT_W-1:0]  new_slots;
    logic [SLOT_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0]  count, nslots;
    logic              push_ok, pop_ok, drop_evt;
    int                words_eff, slots_calc;

    assign region_wr = ctl_wr && (ctl_sel == SEL_REGION);

    always_comb begin
        words_eff  = (int'(ctl_wdata) > MAX_WORDS) ? MAX_WORDS : int'(ctl_wdata);
        slots_calc = words_eff / WPS;
        if (slots_calc < 2) slots_calc = 2;
        new_slots  = CNT_W'(slots_calc);
    end

    qr_ptr_fsm #(
        .SLOT_W      (SLOT_W),
        .CNT_W       (CNT_W),
        .RESET_SLOTS (MAX_SLOTS)
    ) u_ptr (
        .clk          (clk),
        .rst_n        (rst_n),
        .push_req     (wr_advance),
        .pop_req      (cons_pop),
        .reload       (region_wr),
        .reload_slots (new_slots),
        .wr_ptr       (wr_ptr),
        .rd_ptr       (rd_ptr),
        .count        (count),
        .nslots       (nslots),
        .push_ok      (push_ok),
        .pop_ok       (pop_ok),
        .full         (q_full),
        .nonempty     (cons_valid)
    );

    qr_slot_store #(
        .MAX_WORDS (MAX_WORDS),
        .WPS       (WPS),
        .HAS_FLAGS (HAS_FLAGS),
        .AW        (AW),
        .SLOT_W    (SLOT_W)
    ) u_store (
        .clk     (clk),
        .wr_en   (slot_wr_en),
        .wr_addr (slot_wr_addr),
        .wr_data (slot_wr_data),
        .rd_slot (rd_ptr),
        .flags   (cons_flags),
        .addr    (cons_addr),
        .size    (cons_size)
    );

    qr_refill_irq #(
        .CNT_W    (CNT_W),
        .STAT_BIT (STAT_BIT)
    ) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_wr    (ctl_wr),
        .ctl_sel   (ctl_sel),
        .ctl_wdata (ctl_wdata),
        .push_ok   (push_ok),
        .pop_ok    (pop_ok),
        .count     (count),
        .drop_evt  (drop_evt),
        .status    (irq_status),
        .irq       (irq)
    );

    assign fill_level = count;

endmodule

// File: rtl/qr_checker.sv
module qr_checker #(
    parameter int CNT_W    = 5,
    parameter int SLOT_W   = 4,
    parameter int STAT_BIT = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_advance,
    input logic              cons_pop,
    input logic              ctl_wr,
    input logic [1:0]        ctl_sel,
    input logic [15:0]       ctl_wdata,
    input logic              cons_valid,
    input logic              q_full,
    input logic [CNT_W-1:0]  fill_level,
    input logic [15:0]       irq_status,
    input logic              irq,
    input logic [SLOT_W-1:0] wr_ptr,
    input logic [SLOT_W-1:0] rd_ptr,
    input logic [CNT_W-1:0]  nslots,
    input logic              drop_evt
);

    logic region_wr;
    assign region_wr = ctl_wr && (ctl_sel == 2'd0);

    assert_region_reload_R2: assert property (@(posedge clk) disable iff (!rst_n)
        region_wr |=> (fill_level == '0) && !cons_valid && (wr_ptr == '0) && (rd_ptr == '0));

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fill_level < nslots);

    assert_full_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
        q_full == (fill_level == nslots - 1'b1));

    assert_full_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        q_full && wr_advance && !cons_pop && !region_wr |=>
            q_full && (fill_level == $past(fill_level)) && (wr_ptr == $past(wr_ptr)));

    assert_valid_ptrs_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cons_valid == (wr_ptr != rd_ptr));

    assert_empty_pop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !cons_valid && cons_pop && !wr_advance && !region_wr |=>
            !cons_valid && (fill_level == '0) && (rd_ptr == $past(rd_ptr)));

    assert_ptr_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (CNT_W'(wr_ptr) < nslots) && (CNT_W'(rd_ptr) < nslots));

    assert_drop_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
        drop_evt |=> irq_status[STAT_BIT]);

    assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr && (ctl_sel == 2'd3) && ctl_wdata[STAT_BIT] && !drop_evt |=> (irq_status == '0));

    assert_irq_needs_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> irq_status[STAT_BIT]);

endmodule

bind desc_ring_queue qr_checker #(
    .CNT_W    (CNT_W),
    .SLOT_W   (SLOT_W),
    .STAT_BIT (STAT_BIT)
) u_qr_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_advance (wr_advance),
    .cons_pop   (cons_pop),
    .ctl_wr     (ctl_wr),
    .ctl_sel    (ctl_sel),
    .ctl_wdata  (ctl_wdata),
    .cons_valid (cons_valid),
    .q_full     (q_full),
    .fill_level (fill_level),
    .irq_status (irq_status),
    .irq        (irq),
    .wr_ptr     (wr_ptr),
    .rd_ptr     (rd_ptr),
    .nslots     (nslots),
    .drop_evt   (drop_evt)
);

// File: tb/desc_ring_queue_bench.sv
module desc_ring_queue_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic        wr_en = 0, adv = 0, pop = 0, cwr = 0, aud = 0;
    logic [5:0]  waddr = '0;
    logic [15:0] wdata = '0, cdat = '0;
    logic [1:0]  csel = '0;

    logic        v_valid, a_valid, v_full, a_full, v_irq, a_irq;
    logic [15:0] v_flags, a_flags, v_size, a_size, v_stat, a_stat;
    logic [31:0] v_addr, a_addr;
    logic [4:0]  v_fill, a_fill;

    desc_ring_queue u_desc_ring_queue (
        .clk(clk), .rst_n(rst_n),
        .slot_wr_en(wr_en & ~aud), .slot_wr_addr(waddr), .slot_wr_data(wdata),
        .wr_advance(adv & ~aud), .ctl_wr(cwr & ~aud), .ctl_sel(csel), .ctl_wdata(cdat),
        .cons_pop(pop & ~aud), .cons_valid(v_valid), .cons_flags(v_flags),
        .cons_addr(v_addr), .cons_size(v_size), .fill_level(v_fill),
        .q_full(v_full), .irq_status(v_stat), .irq(v_irq)
    );

    desc_ring_queue #(.MAX_WORDS(48), .HAS_FLAGS(1'b0)) u_desc_ring_queue_aud (
        .clk(clk), .rst_n(rst_n),
        .slot_wr_en(wr_en & aud), .slot_wr_addr(waddr), .slot_wr_data(wdata),
        .wr_advance(adv & aud), .ctl_wr(cwr & aud), .ctl_sel(csel), .ctl_wdata(cdat),
        .cons_pop(pop & aud), .cons_valid(a_valid), .cons_flags(a_flags),
        .cons_addr(a_addr), .cons_size(a_size), .fill_level(a_fill),
        .q_full(a_full), .irq_status(a_stat), .irq(a_irq)
    );

    wire        o_valid = aud ? a_valid : v_valid;
    wire        o_full  = aud ? a_full  : v_full;
    wire        o_irq   = aud ? a_irq   : v_irq;
    wire [15:0] o_flags = aud ? a_flags : v_flags;
    wire [15:0] o_size  = aud ? a_size  : v_size;
    wire [15:0] o_stat  = aud ? a_stat  : v_stat;
    wire [31:0] o_addr  = aud ? a_addr  : v_addr;
    wire [4:0]  o_fill  = aud ? a_fill  : v_fill;

    int checks = 0, errors = 0;
    int wps, maxw, sbit;
    int m_ns, m_rd, m_wr, m_cnt, m_thr, next_tag;
    bit m_stat, m_en;
    int m_tag [16];

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] wv(input int t, input int k);
        case (k)
            0:       return 16'hF000 | 16'(t & 'hFFF);
            1:       return 16'(16'h1000 + t);
            2:       return 16'(t * 263);
            default: return 16'(t + 3);
        endcase
    endfunction

    task automatic ctl(input int sel, input int val);
        int w;
        cwr = 1; csel = 2'(sel); cdat = 16'(val);
        @(negedge clk);
        cwr = 0;
        case (sel)
            0: begin
                w = (val > maxw) ? maxw : val;
                m_ns = w / wps;
                if (m_ns < 2) m_ns = 2;
                m_rd = 0; m_wr = 0; m_cnt = 0;
            end
            1: m_thr = val;
            2: m_en = ((val >> sbit) & 1) != 0;
            default: if (((val >> sbit) & 1) != 0) m_stat = 0;
        endcase
    endtask

    task automatic step(input bit p, input bit q, input string req);
        int t, h;
        bit pok, qok;
        t = next_tag;
        if (p) begin
            for (int k = 0; k < wps; k++) begin
                wr_en = 1; waddr = 6'(m_wr * wps + k);
                wdata = wv(t, aud ? k + 1 : k);
                @(negedge clk);
            end
            wr_en = 0;
        end
        if (q && m_cnt > 0) begin
            h = m_tag[m_rd];
            check("R1 head flags", o_flags, aud ? 0 : wv(h, 0));
            check("R5 head address order", o_addr, {wv(h, 1), wv(h, 2)});
            check("R1 head size", o_size, wv(h, 3));
        end
        adv = p; pop = q;
        @(negedge clk);
        adv = 0; pop = 0;
        pok = p && (m_cnt < m_ns - 1);
        qok = q && (m_cnt > 0);
        if (qok && !pok && m_cnt == m_thr && m_thr != 0) m_stat = 1;
        if (pok) begin m_tag[m_wr] = t; next_tag++; m_wr = (m_wr + 1) % m_ns; end
        if (qok) m_rd = (m_rd + 1) % m_ns;
        m_cnt = m_cnt + int'(pok) - int'(qok);
        check(req, o_fill, m_cnt);
        check("R3 full flag", o_full, m_cnt == m_ns - 1);
        check("R4 valid flag", o_valid, m_cnt != 0);
        check("R7 refill status", o_stat, m_stat ? (1 << sbit) : 0);
        check("R9 irq", o_irq, m_stat && m_en);
    endtask

    task automatic run_variant(input bit a);
        int ens;
        aud = a; wps = a ? 3 : 4; maxw = a ? 48 : 64; sbit = a ? 3 : 1;
        m_ns = maxw / wps; m_rd = 0; m_wr = 0; m_cnt = 0; m_thr = 0;
        m_stat = 0; m_en = 0; next_tag = a ? 700 : 1;
        @(negedge clk);
        // R10: reset slot count
        while (m_cnt < m_ns - 1) step(1, 0, "R10 fill from reset");
        check("R10 reset slot count", o_fill, maxw / wps - 1);
        while (m_cnt > 0) step(0, 1, "R10 drain");
        // R2/R3/R4 sweep over every region length
        for (int w = 0; w <= maxw + 6; w++) begin
            ctl(0, w);
            check("R2 fill after region write", o_fill, 0);
            check("R2 valid after region write", o_valid, 0);
            ens = ((w > maxw) ? maxw : w) / wps;
            if (ens < 2) ens = 2;
            while (m_cnt < m_ns - 1) step(1, 0, "R5 fill level");
            check("R2 capacity", o_fill, ens - 1);
            check("R3 full at capacity", o_full, 1);
            step(1, 0, "R3 advance when full ignored");
            while (m_cnt > 0) step(0, 1, "R5 drain level");
            step(0, 1, "R4 pop when empty ignored");
        end
        // R5/R6: wrapping with mixed and simultaneous traffic
        ctl(0, 5 * wps);
        for (int i = 0; i < 80; i++)
            step(i % 4 != 3, (i % 3 == 0) || (i >= 50), "R6 mixed traffic level");
        // R7/R8/R9: refill request
        ctl(0, maxw); ctl(1, 2); ctl(2, 1 << sbit);
        for (int i = 0; i < 3; i++) step(1, 0, "R7 fill");
        step(0, 1, "R7 pop above threshold");
        step(0, 1, "R7 pop crossing threshold");
        check("R7 status after crossing", o_stat, 1 << sbit);
        check("R9 irq enabled", o_irq, 1);
        step(0, 1, "R7 sticky after further pop");
        ctl(3, 'hFFFF & ~(1 << sbit));
        check("R8 ack other bits keeps status", o_stat, 1 << sbit);
        ctl(3, 1 << sbit);
        check("R8 ack clears", o_stat, 0);
        check("R9 irq after ack", o_irq, 0);
        ctl(2, 0);
        for (int i = 0; i < 3; i++) step(1, 0, "R7 refill");
        step(0, 1, "R7 pop");
        step(0, 1, "R7 cross masked");
        check("R7 status while masked", o_stat, 1 << sbit);
        check("R9 irq masked", o_irq, 0);
        ctl(2, 1 << sbit);
        check("R9 irq on enable", o_irq, 1);
        ctl(1, 0);
        ctl(3, 1 << sbit);
        step(1, 0, "R7 thr0 push");
        step(0, 1, "R7 thr0 pop");
        check("R7 threshold 0 never sets", o_stat, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R10 reset fill video", v_fill, 0);
        check("R10 reset valid video", v_valid, 0);
        check("R10 reset full video", v_full, 0);
        check("R10 reset status video", v_stat, 0);
        check("R10 reset irq video", v_irq, 0);
        check("R10 reset fill audio", a_fill, 0);
        check("R10 reset valid audio", a_valid, 0);
        check("R10 reset status audio", a_stat, 0);
        run_variant(1'b0);
        run_variant(1'b1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual running expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule